// File: doc/BRIEF.md
# Branch Direction and Target Predictor

This unit sits beside the fetch stage of a five-stage scalar pipeline. Each cycle it is given the fetch PC and answers, in the same cycle, whether the instruction there is expected to branch and which PC to fetch next. Two tables back the answer. The first is a direct-indexed table of direction counters. The second is a small tagged cache that maps a branch PC to its last taken target. A taken prediction is only made when the counter leans taken and the target cache holds a matching entry. In that case the next PC is the cached target, with no bubble. In every other case fetch falls through to PC + 4.

A resolve port is driven by the later stage that evaluates branches. It carries the branch PC, an is-branch flag, the actual outcome, the actual target, and the prediction that fetch made for that instruction. The unit trains both tables from this port. In the same cycle it flags a misprediction and supplies the corrected PC.

Each counter entry is a small state machine. In the default 2-bit mode it has four states: `CTR_SNT` (00, strongly not taken), `CTR_WNT` (01, weakly not taken), `CTR_WT` (10, weakly taken) and `CTR_ST` (11, strongly taken). A taken outcome steps one state toward `CTR_ST` and a not-taken outcome steps one state toward `CTR_SNT`. Both ends saturate. Setting `CTR_BITS` to 1 replaces this with a single bit that holds the last outcome: 0 means not taken and 1 means taken. A taken outcome moves it to 1 and a not-taken outcome moves it to 0.

Top module: `bpred_unit`

## Requirements
- R1: After reset every 2-bit counter is in state 01 (weakly not taken), every 1-bit counter is 0, and every target entry is invalid. So any fetch PC gives `pred_taken`=0, `pred_hit`=0 and `pred_next_pc` = PC + 4.
- R2: The counter index is PC[log2(PHT_ENTRIES)+1:2]. The target cache index is PC[log2(BTB_ENTRIES)+1:2], and its tag is PC[31:log2(BTB_ENTRIES)+2]. A PC that shares an index with a stored entry but has a different tag gets `pred_hit`=0.
- R3: `pred_taken` is 1 only when the indexed counter predicts taken and the target cache hits. `pred_next_pc` is then the cached target; otherwise it is PC + 4.
- R4: In 2-bit mode a counter predicts taken in states 10 and 11. It saturates at 11 and at 00, so from a strong state it takes two successive opposite outcomes to change the prediction.
- R5: In 1-bit mode the counter stores the last outcome, so a single misprediction flips the prediction.
- R6: Consider an inner-loop branch resolved as taken, taken, taken, not taken, repeated for three outer iterations from reset. The 2-bit mode mispredicts its direction 4 times; the 1-bit mode mispredicts it 6 times, twice per outer iteration.
- R7: A valid taken branch resolve writes its target entry (valid, tag, target), replacing what was there. A not-taken resolve leaves the target cache unchanged and updates only the counter.
- R8: A resolve with `res_valid`=0, or with `res_is_branch`=0, changes neither table.
- R9: With `res_valid`=1, `mispredict` is 1 in three cases: a branch whose actual direction differs from `res_pred_taken`; a taken branch predicted taken whose `res_pred_target` differs from `res_target`; or a non-branch that was predicted taken. `mispredict_pc` is `res_target` for a valid taken branch and `res_pc` + 4 otherwise. With `res_valid`=0, `mispredict` is 0.
- R10: If a lookup and an update address the same entry in the same cycle, the lookup returns the contents held before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | PC being fetched |
| pred_taken | output | 1 | Predicted taken for fetch_pc |
| pred_hit | output | 1 | Target cache holds an entry for fetch_pc |
| pred_next_pc | output | 32 | Predicted next fetch PC |
| res_valid | input | 1 | Resolve port carries an instruction |
| res_is_branch | input | 1 | Resolved instruction is a conditional branch |
| res_taken | input | 1 | Actual branch outcome |
| res_pc | input | 32 | PC of the resolved instruction |
| res_target | input | 32 | Actual branch target |
| res_pred_taken | input | 1 | Direction predicted for it at fetch |
| res_pred_target | input | 32 | Next PC predicted for it at fetch |
| mispredict | output | 1 | Prediction was wrong; redirect fetch |
| mispredict_pc | output | 32 | Correct next PC for the resolved instruction |

## Verification
The bench builds two copies side by side from the same stimulus: one with the defaults (64 counters, 16 target entries, 2-bit counters) and one with `CTR_BITS`=1. Running both copies on one nested-loop trace puts the hysteresis difference in view as plain misprediction counts. With 64 counters against 16 target entries, a PC offset of 256 bytes lands on the same counter and the same target slot but carries a different tag. That reaches the case where a trained counter says taken but no target is available.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_state_e;

    // One training step of a saturating direction counter.
    function automatic ctr_state_e ctr_step(input ctr_state_e cur, input logic taken);
        ctr_state_e nxt;
        unique case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
            default: nxt = CTR_WNT;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/bpred_pht.sv
module bpred_pht
    import bpred_pkg::*;
#(
    parameter int ENTRIES  = 64,
    parameter int CTR_BITS = 2,
    localparam int IW      = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_taken,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_taken
);

    generate
        if (CTR_BITS == 2) begin : g_two
            ctr_state_e tbl [ENTRIES];
            ctr_state_e nxt_state;

            always_comb begin
                nxt_state = ctr_step(tbl[wr_idx], wr_taken);
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < ENTRIES; i++) tbl[i] <= CTR_WNT;
                end else if (wr_en) begin
                    tbl[wr_idx] <= nxt_state;
                end
            end

            always_comb begin
                unique case (tbl[rd_idx])
                    CTR_WT, CTR_ST: rd_taken = 1'b1;
                    default:        rd_taken = 1'b0;
                endcase
            end
        end else begin : g_one
            logic tbl [ENTRIES];

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < ENTRIES; i++) tbl[i] <= 1'b0;
                end else if (wr_en) begin
                    tbl[wr_idx] <= wr_taken;
                end
            end

            always_comb begin
                rd_taken = tbl[rd_idx];
            end
        end
    endgenerate

endmodule

// File: rtl/bpred_btb.sv
module bpred_btb #(
    parameter int ENTRIES = 16,
    parameter int PC_W    = 32,
    localparam int IW     = $clog2(ENTRIES),
    localparam int TAG_W  = PC_W - IW - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [PC_W-1:0]  rd_target,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_target
);

    logic             vld_q [ENTRIES];
    logic [TAG_W-1:0] tag_q [ENTRIES];
    logic [PC_W-1:0]  tgt_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) vld_q[i] <= 1'b0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
        end
    end

    always_comb begin
        rd_hit    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_target = tgt_q[rd_idx];
    end

endmodule

// File: rtl/bpred_unit.sv
module bpred_unit #(
    parameter int PHT_ENTRIES = 64,
    parameter int BTB_ENTRIES = 16,
    parameter int CTR_BITS    = 2,
    localparam int PC_W       = 32,
    localparam int PHT_IW     = $clog2(PHT_ENTRIES),
    localparam int BTB_IW     = $clog2(BTB_ENTRIES),
    localparam int TAG_W      = PC_W - BTB_IW - 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] fetch_pc,
    output logic        pred_taken,
    output logic        pred_hit,
    output logic [31:0] pred_next_pc,
    input  logic        res_valid,
    input  logic        res_is_branch,
    input  logic        res_taken,
    input  logic [31:0] res_pc,
    input  logic [31:0] res_target,
    input  logic        res_pred_taken,
    input  logic [31:0] res_pred_target,
    output logic        mispredict,
    output logic [31:0] mispredict_pc
);

    logic            ctr_taken;
    logic [PC_W-1:0] btb_target;
    logic            train_en;
    logic            alloc_en;

    assign train_en = res_valid && res_is_branch;
    assign alloc_en = train_en && res_taken;

    bpred_pht #(
        .ENTRIES  (PHT_ENTRIES),
        .CTR_BITS (CTR_BITS)
    ) u_pht (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (fetch_pc[PHT_IW+1:2]),
        .rd_taken (ctr_taken),
        .wr_en    (train_en),
        .wr_idx   (res_pc[PHT_IW+1:2]),
        .wr_taken (res_taken)
    );

    bpred_btb #(
        .ENTRIES (BTB_ENTRIES),
        .PC_W    (PC_W)
    ) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (fetch_pc[BTB_IW+1:2]),
        .rd_tag    (fetch_pc[PC_W-1:BTB_IW+2]),
        .rd_hit    (pred_hit),
        .rd_target (btb_target),
        .wr_en     (alloc_en),
        .wr_idx    (res_pc[BTB_IW+1:2]),
        .wr_tag    (res_pc[PC_W-1:BTB_IW+2]),
        .wr_target (res_target)
    );

    // Fetch-side steering: taken needs both a taken-leaning counter and a target.
    always_comb begin
        pred_taken   = ctr_taken && pred_hit;
        pred_next_pc = pred_taken ? btb_target : fetch_pc + 32'd4;
    end

    // Resolve-side check against what fetch predicted for this instruction.
    always_comb begin
        mispredict_pc = alloc_en ? res_target : res_pc + 32'd4;
        if (!res_valid) begin
            mispredict = 1'b0;
        end else if (!res_is_branch) begin
            mispredict = res_pred_taken;
        end else if (res_taken != res_pred_taken) begin
            mispredict = 1'b1;
        end else begin
            mispredict = res_taken && (res_pred_target != res_target);
        end
    end

endmodule

// File: rtl/bpred_unit_chk.sv
module bpred_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] fetch_pc,
    input logic        pred_taken,
    input logic        pred_hit,
    input logic [31:0] pred_next_pc,
    input logic        res_valid,
    input logic        res_is_branch,
    input logic        res_taken,
    input logic [31:0] res_pc,
    input logic [31:0] res_target,
    input logic        res_pred_taken,
    input logic [31:0] res_pred_target,
    input logic        mispredict,
    input logic [31:0] mispredict_pc
);

    // R3: without a target entry fetch must fall through
    p_fallthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> (!pred_taken && pred_next_pc == fetch_pc + 32'd4));

    // R7: an entry is only displaced by a taken branch resolve
    p_entry_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pred_hit) && $stable(fetch_pc)
         && !$past(res_valid && res_is_branch && res_taken)) |-> pred_hit);

    // R7: a taken resolve leaves a matching entry behind
    p_alloc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(res_valid && res_is_branch && res_taken) && fetch_pc == $past(res_pc))
        |-> pred_hit);

    // R9: direction disagreement on a branch raises a redirect
    p_dir_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_is_branch && (res_taken != res_pred_taken)) |-> mispredict);

    // R9: wrong cached target on a taken branch redirects to the real target
    p_tgt_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_is_branch && res_taken && res_pred_taken
         && res_pred_target != res_target)
        |-> (mispredict && mispredict_pc == res_target));

    // R9: an idle resolve port never redirects
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !mispredict);

endmodule

bind bpred_unit bpred_unit_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_pc        (fetch_pc),
    .pred_taken      (pred_taken),
    .pred_hit        (pred_hit),
    .pred_next_pc    (pred_next_pc),
    .res_valid       (res_valid),
    .res_is_branch   (res_is_branch),
    .res_taken       (res_taken),
    .res_pc          (res_pc),
    .res_target      (res_target),
    .res_pred_taken  (res_pred_taken),
    .res_pred_target (res_pred_target),
    .mispredict      (mispredict),
    .mispredict_pc   (mispredict_pc)
);

// File: tb/sim_bpred_unit.sv
`timescale 1ns/1ps
module sim_bpred_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        res_valid = 1'b0;
    logic        res_is_branch = 1'b0;
    logic        res_taken = 1'b0;
    logic [31:0] res_pc = '0;
    logic [31:0] res_target = '0;
    logic        res_pred_taken = 1'b0;
    logic [31:0] res_pred_target = '0;

    logic        p0_taken, p0_hit, p1_taken, p1_hit, mp0, mp1;
    logic [31:0] p0_next, p1_next, mpc0, mpc1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bpred_unit #(.CTR_BITS(2)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_taken(p0_taken), .pred_hit(p0_hit), .pred_next_pc(p0_next),
        .res_valid(res_valid), .res_is_branch(res_is_branch), .res_taken(res_taken),
        .res_pc(res_pc), .res_target(res_target),
        .res_pred_taken(res_pred_taken), .res_pred_target(res_pred_target),
        .mispredict(mp0), .mispredict_pc(mpc0)
    );

    bpred_unit #(.CTR_BITS(1)) u1 (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_taken(p1_taken), .pred_hit(p1_hit), .pred_next_pc(p1_next),
        .res_valid(res_valid), .res_is_branch(res_is_branch), .res_taken(res_taken),
        .res_pc(res_pc), .res_target(res_target),
        .res_pred_taken(res_pred_taken), .res_pred_target(res_pred_target),
        .mispredict(mp1), .mispredict_pc(mpc1)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        res_valid = 1'b0;
        fetch_pc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Present fetch PC and let combinational outputs settle (called at a negedge).
    task automatic look(input logic [31:0] pc);
        fetch_pc = pc;
        #1;
    endtask

    // Drive one resolve for a full cycle; mp0/mpc0 are valid at return -1 cycle.
    logic smp_mp0;
    logic [31:0] smp_mpc0;
    task automatic resolve(input logic v, input logic br, input logic tk,
                           input logic [31:0] pc, input logic [31:0] tgt,
                           input logic ptk, input logic [31:0] ptgt);
        res_valid = v; res_is_branch = br; res_taken = tk;
        res_pc = pc; res_target = tgt;
        res_pred_taken = ptk; res_pred_target = ptgt;
        #1;
        smp_mp0 = mp0;
        smp_mpc0 = mpc0;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        look(32'h0000_0100);
        check("R1 u0 taken", 32'(p0_taken), 32'd0);
        check("R1 u0 hit", 32'(p0_hit), 32'd0);
        check("R1 u0 next", p0_next, 32'h0000_0104);
        check("R1 u1 taken", 32'(p1_taken), 32'd0);
        check("R1 u1 next", p1_next, 32'h0000_0104);
    endtask

    task automatic t_target();
        do_reset();
        resolve(1, 1, 1, 32'h1000, 32'h2000, 0, 32'h1004);
        look(32'h1000);
        check("R3 taken after alloc", 32'(p0_taken), 32'd1);
        check("R3 next is target", p0_next, 32'h2000);
        look(32'h1004);
        check("R2 neighbour slot miss", 32'(p0_hit), 32'd0);
        resolve(1, 1, 0, 32'h1000, 32'h0, 1, 32'h2000);
        look(32'h1000);
        check("R7 not-taken keeps entry", 32'(p0_hit), 32'd1);
        check("R3 weak NT falls through", p0_next, 32'h1004);
        resolve(1, 1, 1, 32'h1000, 32'h3000, 0, 32'h1004);
        look(32'h1000);
        check("R7 target overwritten", p0_next, 32'h3000);
        look(32'h1100);
        check("R2 tag mismatch miss", 32'(p0_hit), 32'd0);
        check("R3 counter taken but no target", 32'(p0_taken), 32'd0);
        check("R3 no target falls through", p0_next, 32'h1104);
    endtask

    task automatic t_saturate();
        do_reset();
        repeat (4) resolve(1, 1, 1, 32'h40, 32'h80, 0, 32'h44);
        resolve(1, 1, 0, 32'h40, 32'h0, 1, 32'h80);
        look(32'h40);
        check("R4 one NT from strong keeps taken", 32'(p0_taken), 32'd1);
        check("R5 one NT flips 1-bit", 32'(p1_taken), 32'd0);
        resolve(1, 1, 0, 32'h40, 32'h0, 1, 32'h80);
        look(32'h40);
        check("R4 second NT flips", 32'(p0_taken), 32'd0);
        repeat (3) resolve(1, 1, 0, 32'h40, 32'h0, 0, 32'h44);
        resolve(1, 1, 1, 32'h40, 32'h80, 0, 32'h44);
        look(32'h40);
        check("R4 low end saturates", 32'(p0_taken), 32'd0);
        check("R5 one T flips 1-bit", 32'(p1_taken), 32'd1);
        resolve(1, 1, 1, 32'h40, 32'h80, 0, 32'h44);
        look(32'h40);
        check("R4 two T from strong NT", 32'(p0_taken), 32'd1);
    endtask

    task automatic t_loop();
        int miss0 = 0;
        int miss1 = 0;
        do_reset();
        for (int o = 0; o < 3; o++) begin
            for (int i = 0; i < 4; i++) begin
                logic act;
                logic pt;
                logic [31:0] pn;
                act = (i < 3);
                look(32'h200);
                pt = p0_taken;
                pn = p0_next;
                if (p0_taken != act) miss0++;
                if (p1_taken != act) miss1++;
                resolve(1, 1, act, 32'h200, 32'h1C0, pt, pn);
                check("R9 loop redirect", 32'(smp_mp0),
                      32'((pt != act) || (act && pn != 32'h1C0)));
            end
        end
        check("R6 2-bit loop misses", 32'(miss0), 32'd4);
        check("R6 1-bit loop misses", 32'(miss1), 32'd6);
    endtask

    task automatic t_mispredict();
        do_reset();
        resolve(1, 1, 1, 32'h500, 32'h600, 0, 32'h504);
        check("R9 taken vs NT flag", 32'(smp_mp0), 32'd1);
        check("R9 taken vs NT pc", smp_mpc0, 32'h600);
        resolve(1, 1, 0, 32'h504, 32'h0, 1, 32'h700);
        check("R9 NT vs T flag", 32'(smp_mp0), 32'd1);
        check("R9 NT vs T pc", smp_mpc0, 32'h508);
        resolve(1, 1, 1, 32'h508, 32'h600, 1, 32'h640);
        check("R9 wrong target flag", 32'(smp_mp0), 32'd1);
        check("R9 wrong target pc", smp_mpc0, 32'h600);
        resolve(1, 1, 1, 32'h50C, 32'h600, 1, 32'h600);
        check("R9 correct taken", 32'(smp_mp0), 32'd0);
        resolve(1, 0, 0, 32'h510, 32'h0, 1, 32'h900);
        check("R9 non-branch predicted taken", 32'(smp_mp0), 32'd1);
        check("R9 non-branch pc", smp_mpc0, 32'h514);
        resolve(0, 1, 1, 32'h520, 32'h600, 0, 32'h524);
        check("R9 idle port quiet", 32'(smp_mp0), 32'd0);
    endtask

    task automatic t_no_update();
        do_reset();
        resolve(1, 0, 1, 32'h900, 32'hA00, 0, 32'h904);
        look(32'h900);
        check("R8 non-branch no alloc", 32'(p0_hit), 32'd0);
        resolve(0, 1, 1, 32'h900, 32'hA00, 0, 32'h904);
        look(32'h900);
        check("R8 invalid no alloc", 32'(p0_hit), 32'd0);
        check("R8 next unchanged", p0_next, 32'h904);
    endtask

    task automatic t_same_cycle();
        do_reset();
        fetch_pc = 32'hC00;
        res_valid = 1; res_is_branch = 1; res_taken = 1;
        res_pc = 32'hC00; res_target = 32'hD00;
        res_pred_taken = 0; res_pred_target = 32'hC04;
        #1;
        check("R10 old hit seen", 32'(p0_hit), 32'd0);
        check("R10 old next seen", p0_next, 32'hC04);
        @(negedge clk);
        res_valid = 0;
        #1;
        check("R10 new entry after edge", p0_next, 32'hD00);
    endtask

    initial begin
        t_reset();
        t_target();
        t_saturate();
        t_loop();
        t_mispredict();
        t_no_update();
        t_same_cycle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule